// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to sixteen interrupt inputs and turns them into a single prioritized request toward a processor. Each input has its own byte-wide control register. That register sets the input's request level, its enable, whether it is sensed by level or by edge, and which polarity counts as asserted. A global control register holds a master enable. A second register holds the vector base.

Inputs pass through a two-stage synchronizer. In edge mode a qualifying transition is latched and stays pending until software writes a one to the clear bit of that input's register. The output request level is the highest level among the inputs that are pending and enabled. When the processor raises the acknowledge strobe, the block returns the vector base plus the index of the winning input. Among inputs at the winning level, the highest index wins.

Registers are reached through a synchronous byte port. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `prio_vec_irq`

## Requirements
- R1: After reset every register reads 0x00, the request level is 0, and an acknowledge returns 0xFF.
- R2: Source register N sits at address N (0x00 to 0x0F), the global control register at 0x10 (bit 1 is the master enable), and the vector base at 0x11. In a source register, bits 7, 6, 4 and 2:0 read back as written, bit 3 always reads 0, and bit 5 reads the active flag. Unmapped addresses read 0x00.
- R3: Bit 6 = 0 selects level sensing. In this mode the active flag (bit 5) is set while the synchronized input equals 1 for bit 7 = 0, or equals 0 for bit 7 = 1.
- R4: Bit 6 = 1 selects edge sensing. A rising edge (bit 7 = 0) or a falling edge (bit 7 = 1) on the synchronized input sets a pending latch that drives the active flag. Writing the register with bit 3 = 1 clears the latch. A write with bit 3 = 0 leaves it set, and an edge of the opposite direction is not captured.
- R5: If a clear write and a newly detected edge on the same input meet in the same cycle, the edge is kept pending.
- R6: An input is pending only when it is active, its enable (bit 4) is 1 and its level field (bits 2:0) is nonzero. No request leaves the block (level 0) unless the master enable is 1.
- R7: The request level equals the maximum level field among pending inputs.
- R8: On acknowledge the vector is (base + winner index) mod 256. The winner is the highest index among the pending inputs at the maximum level.
- R9: On acknowledge with no pending input, or with the master enable clear, the vector is 0xFF.
- R10: While the acknowledge strobe is low the vector output is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Raw interrupt inputs, one per source |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_level | output | 3 | Request level toward the processor, 0 = none |
| iack | input | 1 | Acknowledge strobe |
| iack_vec | output | 8 | Vector returned during acknowledge |

## Verification
Edge capture and the software clear can act on the same pending latch in the same cycle. The bench provokes this by raising one edge-mode input and timing a clear write so that it lands at the clock edge where the synchronized transition is first detected. It then reads the register back and expects the active flag still set. A second clear write afterwards shows that the clear path works on its own. Random level-mode configurations and input patterns are checked against a bench model of the maximum-level, highest-index selection and the resulting vector.

// File: rtl/prio_vec_irq.sv
module prio_vec_irq #(
  parameter int NSRC = 16,
  parameter logic [7:0] SPUR_VEC = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [5:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic [2:0]      irq_level,
  input  logic            iack,
  output logic [7:0]      iack_vec
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [5:0] GCTL_A = 6'(NSRC);
  localparam logic [5:0] VBASE_A = 6'(NSRC + 1);

  logic [7:0]      cfg_q [NSRC];
  logic            mie_q;
  logic [7:0]      vbase_q;
  logic [NSRC-1:0] s1_q, s2_q, s3_q, lat_q;
  logic [NSRC-1:0] clr_v, hit_v, act_v, pend_v;
  logic [2:0]      best_lvl;
  logic [IW-1:0]   best_idx;
  logic            any_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
      mie_q <= 1'b0;
      vbase_q <= '0;
    end else begin
      s1_q <= src_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (reg_wr && reg_addr == GCTL_A) mie_q <= reg_wdata[1];
      if (reg_wr && reg_addr == VBASE_A) vbase_q <= reg_wdata;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    wire sel = (reg_addr == 6'(i));
    assign clr_v[i] = reg_wr && sel && reg_wdata[3];
    assign hit_v[i] = cfg_q[i][7] ? (s3_q[i] & ~s2_q[i]) : (s2_q[i] & ~s3_q[i]);
    assign act_v[i] = cfg_q[i][6] ? lat_q[i] : (s2_q[i] ^ cfg_q[i][7]);
    assign pend_v[i] = act_v[i] && cfg_q[i][4] && (cfg_q[i][2:0] != 3'd0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
        lat_q[i] <= 1'b0;
      end else begin
        if (reg_wr && sel) cfg_q[i] <= reg_wdata & 8'hD7;
        lat_q[i] <= (lat_q[i] & ~clr_v[i]) | (cfg_q[i][6] & hit_v[i]);
      end
    end
  end

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    any_pend = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_v[i] && cfg_q[i][2:0] >= best_lvl) begin
        best_lvl = cfg_q[i][2:0];
        best_idx = IW'(i);
        any_pend = 1'b1;
      end
    end
  end

  wire req_ok = mie_q && any_pend;
  assign irq_level = req_ok ? best_lvl : 3'd0;
  assign iack_vec = !iack ? 8'h00 : req_ok ? vbase_q + 8'(best_idx) : SPUR_VEC;

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NSRC; i++)
      if (reg_addr == 6'(i)) reg_rdata = cfg_q[i] | {2'b00, act_v[i], 5'b0};
    if (reg_addr == GCTL_A) reg_rdata = {6'b0, mie_q, 1'b0};
    if (reg_addr == VBASE_A) reg_rdata = vbase_q;
  end
endmodule

module prio_vec_irq_chk #(
  parameter int NSRC = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mie,
  input logic [2:0]      irq_level,
  input logic            iack,
  input logic [7:0]      iack_vec,
  input logic [7:0]      vbase,
  input logic [NSRC-1:0] lat,
  input logic [NSRC-1:0] clr
);
  p_gate_by_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mie |-> irq_level == 3'd0);
  p_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && irq_level == 3'd0) |-> iack_vec == 8'hFF);
  p_vec_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && irq_level != 3'd0) |-> 8'(iack_vec - vbase) < 8'(NSRC));
  p_idle_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |-> iack_vec == 8'h00);
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lat) & ~$past(clr)) & ~lat) == '0);
endmodule

bind prio_vec_irq prio_vec_irq_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mie(mie_q), .irq_level(irq_level), .iack(iack),
  .iack_vec(iack_vec), .vbase(vbase_q), .lat(lat_q), .clr(clr_v)
);

// File: tb/prio_vec_irq_tb.sv
module prio_vec_irq_tb;
  localparam int N = 16;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0;
  logic [5:0] addr = '0;
  logic wr = 0, iack = 0;
  logic [7:0] wdata = '0, rdata, vec;
  logic [2:0] lvl;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_cfg [N];
  logic m_mie;
  logic [7:0] m_base;

  always #2.5 clk = ~clk;

  prio_vec_irq u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr(addr), .reg_wr(wr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_level(lvl), .iack(iack), .iack_vec(vec)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1;
    if (a < 6'(N)) m_cfg[a] = d & 8'hD7;
    if (a == 6'h10) m_mie = d[1];
    if (a == 6'h11) m_base = d;
    @(posedge clk);
    #1 wr = 0;
  endtask

  task automatic rreg(logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk);
    iack = 1;
    #1 v = vec;
    @(negedge clk);
    iack = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  function automatic logic m_pend(int i);
    logic a = src[i] ^ m_cfg[i][7];
    return a && m_cfg[i][4] && (m_cfg[i][2:0] != 0);
  endfunction

  function automatic logic [2:0] m_level();
    logic [2:0] b = 0;
    if (!m_mie) return 0;
    for (int i = 0; i < N; i++) if (m_pend(i) && m_cfg[i][2:0] > b) b = m_cfg[i][2:0];
    return b;
  endfunction

  function automatic logic [7:0] m_vec();
    logic [2:0] b = m_level();
    logic [7:0] v = 8'hFF;
    if (b == 0) return v;
    for (int i = 0; i < N; i++) if (m_pend(i) && m_cfg[i][2:0] == b) v = m_base + 8'(i);
    return v;
  endfunction

  task automatic clean();
    for (int i = 0; i < N; i++) wreg(6'(i), 8'h08);
    src = '0;
    settle();
  endtask

  initial begin
    #1ms;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) m_cfg[i] = 0;
    m_mie = 0; m_base = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 18; a++) begin rreg(6'(a), d); chk("R1 reg", d, 8'h00); end
    chk("R1 level", 8'(lvl), 8'h00);
    ack(d); chk("R1 ack", d, 8'hFF);

    // R2 readback
    wreg(6'd3, 8'hFF); rreg(6'd3, d); chk("R2 src reg", d, 8'hD7);
    wreg(6'h11, 8'h50); rreg(6'h11, d); chk("R2 base", d, 8'h50);
    wreg(6'h10, 8'hFF); rreg(6'h10, d); chk("R2 gctl", d, 8'h02);
    wreg(6'h10, 8'h00);
    rreg(6'h20, d); chk("R2 unmapped", d, 8'h00);
    clean();

    // R3 level sensing
    wreg(6'd5, 8'h00); src[5] = 1; settle();
    rreg(6'd5, d); chk("R3 high active", d, 8'h20);
    wreg(6'd5, 8'h80); rreg(6'd5, d); chk("R3 low pol inactive", d, 8'h80);
    src[5] = 0; settle(); rreg(6'd5, d); chk("R3 low pol active", d, 8'hA0);
    clean();

    // R4 edge capture and clear
    wreg(6'd7, 8'h40);
    @(negedge clk) src[7] = 1; @(negedge clk) src[7] = 0; settle();
    rreg(6'd7, d); chk("R4 rise captured", d, 8'h60);
    wreg(6'd7, 8'h40); rreg(6'd7, d); chk("R4 no clear w/o bit3", d, 8'h60);
    wreg(6'd7, 8'h48); rreg(6'd7, d); chk("R4 cleared", d, 8'h40);
    wreg(6'd7, 8'hC0); src[7] = 1; settle();
    rreg(6'd7, d); chk("R4 rise ignored in fall mode", d, 8'hC0);
    src[7] = 0; settle(); rreg(6'd7, d); chk("R4 fall captured", d, 8'hE0);
    wreg(6'd7, 8'hC8); rreg(6'd7, d); chk("R4 fall cleared", d, 8'hC0);
    clean();

    // R5 clear and edge in the same cycle
    wreg(6'd2, 8'h40);
    @(negedge clk) src[2] = 1;
    @(posedge clk); @(posedge clk);
    wreg(6'd2, 8'h48);
    rreg(6'd2, d); chk("R5 edge wins over clear", d, 8'h60);
    wreg(6'd2, 8'h48); rreg(6'd2, d); chk("R5 later clear", d, 8'h40);
    clean();

    // R6..R10 directed priority
    wreg(6'h11, 8'h50);
    wreg(6'd9, 8'h93); settle();
    chk("R6 mie off level", 8'(lvl), 8'h00);
    ack(d); chk("R9 mie off spurious", d, 8'hFF);
    wreg(6'h10, 8'h02);
    chk("R7 single level", 8'(lvl), 8'h03);
    ack(d); chk("R8 single vec", d, 8'h59);
    wreg(6'd12, 8'h93);
    ack(d); chk("R8 tie highest index", d, 8'h5C);
    wreg(6'd4, 8'h96);
    chk("R7 max level", 8'(lvl), 8'h06);
    ack(d); chk("R8 max level vec", d, 8'h54);
    wreg(6'd4, 8'h86);
    ack(d); chk("R6 enable off", d, 8'h5C);
    wreg(6'd12, 8'h90);
    ack(d); chk("R6 level zero ignored", d, 8'h59);
    wreg(6'h11, 8'hF8);
    ack(d); chk("R8 base wrap", d, 8'h01);
    #1 chk("R10 idle vec", vec, 8'h00);
    wreg(6'd9, 8'h00);
    ack(d); chk("R9 none pending", d, 8'hFF);
    clean();

    // random level-mode phase
    for (int it = 0; it < 150; it++) begin
      for (int k = 0; k < 3; k++) begin
        int s = $urandom_range(N - 1);
        logic [7:0] c = 8'($urandom) & 8'h97;
        wreg(6'(s), c);
      end
      if (it % 10 == 0) wreg(6'h11, 8'($urandom));
      wreg(6'h10, ($urandom_range(3) != 0) ? 8'h02 : 8'h00);
      src = N'($urandom);
      settle();
      chk("R7 random level", 8'(lvl), 8'(m_level()));
      ack(d); chk("R8 random vec", d, m_vec());
      begin
        int s = $urandom_range(N - 1);
        rreg(6'(s), d);
        chk("R3 random readback", d, m_cfg[s] | {2'b0, src[s] ^ m_cfg[s][7], 5'b0});
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule